// File: doc/BRIEF.md
# Serial Channel Mode, Command and Status Register Front End

This block is the host-facing register slice of one serial channel. A byte-wide write and read bus reaches four channel-relative offsets. Behind them sit three mode registers that share one offset and are selected by a pointer, a clock-select byte, a command port that starts and stops the receiver and transmitter, and a status byte. The block turns these into steady control levels for a separate transmitter and receiver: word length, parity mode, stop length, FIFO depth mode, transmit threshold, enables and a break request. It also emits single-cycle flush strobes and holding-register push and pop strobes.

The mode pointer advances by one on every access to the mode offset and stays on the last register once it gets there. Commands move it back. One command byte carries independent enable and disable bits for both directions and an encoded action nibble, and all of them act in the same write. Error flags from the receiver are pulses. The block holds them in the status byte until a command clears them.

Top module: `uart_chan_regs`

## Requirements
- R1: Offsets: 0 is the mode register selected by the pointer (read and write); 1 reads status and writes the clock-select byte (`clk_sel_o`); 2 is the command port (reads return 0); 3 reads the receive byte (`rx_data_i`) with a one-cycle `rx_pop_o`, and a write there gives a one-cycle `tx_push_o` with `tx_data_o` equal to the written byte. When `rd_en` is low, `rdata` is 0.
- R2: After reset the pointer selects the first-format register, all mode registers and the clock-select byte are 0, both directions are disabled, no break is requested and the held error bits are 0.
- R3: In a command write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When enable and disable are both set, disable wins. These bits are applied after the nibble's own effect in the same write.
- R4: Command nibble 1 points the pointer at the first-format register (data bits and parity). Nibble 0xB points it at the FIFO-mode register when `HAS_FIFO_MR` is 1, and acts like nibble 1 otherwise.
- R5: Each read or write at offset 0 moves the pointer from the FIFO-mode register to the first-format register, then to the stop register, where it stays.
- R6: `word_len_o` is first-format bits 1:0 (codes 0..3 give 5..8 data bits). `parity_mode_o` is bits 4:2 (0 even, 1 odd, 4 none).
- R7: `stop_two_o` is bit 3 of the stop register, so low nibble 0x7 gives one stop bit and 0xF gives two.
- R8: `fifo_deep_o` is FIFO-mode bit 3 and `tx_half_o` is FIFO-mode bit 4.
- R9: Status bit 0 receive-ready, bit 1 receive-full, bit 2 transmit-ready and bit 3 transmitter-empty follow the engine inputs. Bits 4 overrun, 5 parity, 6 framing and 7 break latch on an input pulse and hold.
- R10: Nibble 4 clears status bits 7:4 and nibble 5 clears bit 7 only. A pulse that arrives in the same cycle as a clear still sets its bit.
- R11: Nibble 6 raises `break_o` and nibble 7 drops it.
- R12: Nibble 2 gives a one-cycle `rx_flush_o`, disables the receiver and returns the pointer to the first-format register. Status bits 1:0 then read 0 until both `rx_rdy_i` and `rx_full_i` have been low for a clock.
- R13: Nibble 3 gives a one-cycle `tx_flush_o`, disables the transmitter, drops `break_o` and returns the pointer to the first-format register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | OFS_W | Channel-relative offset |
| wdata | input | DATA_W | Host write byte |
| rdata | output | DATA_W | Host read byte, combinational |
| rx_data_i | input | DATA_W | Byte at the head of the receive queue |
| rx_rdy_i | input | 1 | Receiver holds a byte |
| rx_full_i | input | 1 | Receive queue full |
| tx_rdy_i | input | 1 | Transmitter can accept a byte |
| tx_empty_i | input | 1 | Transmitter idle and empty |
| ovr_pulse_i | input | 1 | Overrun event pulse |
| par_pulse_i | input | 1 | Parity error pulse |
| frm_pulse_i | input | 1 | Framing error pulse |
| brk_pulse_i | input | 1 | Received break pulse |
| tx_push_o | output | 1 | Byte written to transmit holding |
| tx_data_o | output | DATA_W | Byte to transmit |
| rx_pop_o | output | 1 | Receive byte consumed |
| rx_flush_o | output | 1 | Receiver reset strobe |
| tx_flush_o | output | 1 | Transmitter reset strobe |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| word_len_o | output | 2 | Data bit count code |
| parity_mode_o | output | 3 | Parity mode code |
| stop_two_o | output | 1 | Two stop bits |
| fifo_deep_o | output | 1 | Deeper FIFO mode |
| tx_half_o | output | 1 | Transmit-ready at half-full |
| break_o | output | 1 | Send break |
| clk_sel_o | output | DATA_W | Clock-select byte |

## Verification
The pointer is tried with a run of three mode writes after a repositioning command, which shows whether it stops on the last register or wraps. A read after a second repositioning shows that reads advance it too. Command bytes go in with enable alone, enable and disable together, and a reset nibble combined with an enable bit. These patterns tell disable-priority and same-write ordering apart from a plain decode. Error pulses are given one at a time, and clear commands are given both separately and in the same cycle as a new pulse. This separates the clear-all and break-only clears and shows whether a new pulse survives a clear. The receive-reset mask is checked with the engine flags held high, then dropped, then raised again.

// File: rtl/uart_chan_pkg.sv
`timescale 1ns/1ps
package uart_chan_pkg;

   typedef enum logic [1:0] {
      PTR_FIFO = 2'd0,
      PTR_FMT  = 2'd1,
      PTR_STOP = 2'd2
   } mr_ptr_t;

   localparam int OFS_MODE = 0;
   localparam int OFS_STAT = 1;
   localparam int OFS_CMD  = 2;
   localparam int OFS_HOLD = 3;

   localparam logic [3:0] NIB_PTR_FMT  = 4'h1;
   localparam logic [3:0] NIB_RX_RST   = 4'h2;
   localparam logic [3:0] NIB_TX_RST   = 4'h3;
   localparam logic [3:0] NIB_ERR_CLR  = 4'h4;
   localparam logic [3:0] NIB_CHG_CLR  = 4'h5;
   localparam logic [3:0] NIB_BRK_ON   = 4'h6;
   localparam logic [3:0] NIB_BRK_OFF  = 4'h7;
   localparam logic [3:0] NIB_PTR_FIFO = 4'hB;

   typedef struct packed {
      logic rx_on;
      logic rx_off;
      logic tx_on;
      logic tx_off;
      logic ptr_fmt;
      logic ptr_fifo;
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic chg_clr;
      logic brk_on;
      logic brk_off;
   } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
`timescale 1ns/1ps
module uart_cmd_decode
   import uart_chan_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit HAS_FIFO_MR = 1'b1
) (
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_byte,
   output cmd_t              cmd
);

   localparam int NIB_LO = DATA_W - 4;

   logic [3:0] nib;
   assign nib = cmd_byte[DATA_W-1:NIB_LO];

   always_comb begin
      cmd = '0;
      if (cmd_wr) begin
         cmd.rx_on  = cmd_byte[0];
         cmd.rx_off = cmd_byte[1];
         cmd.tx_on  = cmd_byte[2];
         cmd.tx_off = cmd_byte[3];
         case (nib)
            NIB_PTR_FMT:  cmd.ptr_fmt = 1'b1;
            NIB_RX_RST:   cmd.rx_rst  = 1'b1;
            NIB_TX_RST:   cmd.tx_rst  = 1'b1;
            NIB_ERR_CLR:  cmd.err_clr = 1'b1;
            NIB_CHG_CLR:  cmd.chg_clr = 1'b1;
            NIB_BRK_ON:   cmd.brk_on  = 1'b1;
            NIB_BRK_OFF:  cmd.brk_off = 1'b1;
            NIB_PTR_FIFO: begin
               if (HAS_FIFO_MR) cmd.ptr_fifo = 1'b1;
               else             cmd.ptr_fmt  = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/uart_mode_regs.sv
`timescale 1ns/1ps
module uart_mode_regs
   import uart_chan_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit HAS_FIFO_MR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_acc,
   input  logic              mode_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              go_fmt,
   input  logic              go_fifo,
   output logic [DATA_W-1:0] fifo_mr,
   output logic [DATA_W-1:0] fmt_mr,
   output logic [DATA_W-1:0] stop_mr,
   output logic [DATA_W-1:0] cur_mr
);

   mr_ptr_t ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= PTR_FMT;
      end else if (go_fmt) begin
         ptr <= PTR_FMT;
      end else if (go_fifo) begin
         ptr <= PTR_FIFO;
      end else if (mode_acc) begin
         case (ptr)
            PTR_FIFO: ptr <= PTR_FMT;
            default:  ptr <= PTR_STOP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_mr  <= '0;
         stop_mr <= '0;
      end else if (mode_wr) begin
         if (ptr == PTR_FMT)  fmt_mr  <= wdata;
         if (ptr == PTR_STOP) stop_mr <= wdata;
      end
   end

   generate
      if (HAS_FIFO_MR) begin : g_fifo_mr
         logic [DATA_W-1:0] fifo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          fifo_q <= '0;
            else if (mode_wr && ptr == PTR_FIFO) fifo_q <= wdata;
         end
         assign fifo_mr = fifo_q;
      end else begin : g_no_fifo_mr
         assign fifo_mr = '0;
      end
   endgenerate

   always_comb begin
      case (ptr)
         PTR_FIFO: cur_mr = fifo_mr;
         PTR_FMT:  cur_mr = fmt_mr;
         default:  cur_mr = stop_mr;
      endcase
   end

   AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ptr != 2'd3); // R5
   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_acc && !go_fmt && !go_fifo && ptr == PTR_FMT) |=> ptr == PTR_STOP); // R5
   AST_PTR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_acc && !go_fmt && !go_fifo && ptr == PTR_STOP) |=> ptr == PTR_STOP); // R5
   AST_PTR_REPOINT: assert property (@(posedge clk) disable iff (!rst_n)
      go_fmt |=> ptr == PTR_FMT); // R4

endmodule

// File: rtl/uart_status_reg.sv
`timescale 1ns/1ps
module uart_status_reg #(
   parameter int DATA_W  = 8,
   parameter int ERR_CNT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_rdy,
   input  logic               rx_full,
   input  logic               tx_rdy,
   input  logic               tx_empty,
   input  logic [ERR_CNT-1:0] err_in,
   input  logic               err_clr,
   input  logic               chg_clr,
   input  logic               rx_rst,
   output logic [DATA_W-1:0]  status
);

   localparam int LIVE_CNT = DATA_W - ERR_CNT;
   localparam int BRK_BIT  = ERR_CNT - 1;

   logic [ERR_CNT-1:0] held, held_nxt;
   logic               rx_mask;

   always_comb begin
      held_nxt = held;
      if (err_clr) held_nxt = '0;
      if (chg_clr) held_nxt[BRK_BIT] = 1'b0;
      held_nxt = held_nxt | err_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= held_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rx_mask <= 1'b0;
      else if (rx_rst)               rx_mask <= 1'b1;
      else if (!(rx_rdy || rx_full)) rx_mask <= 1'b0;
   end

   logic [LIVE_CNT-1:0] live;
   assign live   = LIVE_CNT'({tx_empty, tx_rdy, rx_full & ~rx_mask, rx_rdy & ~rx_mask});
   assign status = {held, live};

   AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_clr && !chg_clr) |=> ((status[DATA_W-1:LIVE_CNT] & $past(status[DATA_W-1:LIVE_CNT]))
                                  == $past(status[DATA_W-1:LIVE_CNT]))); // R9
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && err_in == '0) |=> status[DATA_W-1:LIVE_CNT] == '0); // R10
   AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> status[1:0] == 2'b00); // R12

endmodule

// File: rtl/uart_chan_regs.sv
`timescale 1ns/1ps
module uart_chan_regs
   import uart_chan_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OFS_W       = 2,
   parameter bit HAS_FIFO_MR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFS_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_rdy_i,
   input  logic              rx_full_i,
   input  logic              tx_rdy_i,
   input  logic              tx_empty_i,
   input  logic              ovr_pulse_i,
   input  logic              par_pulse_i,
   input  logic              frm_pulse_i,
   input  logic              brk_pulse_i,
   output logic              tx_push_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              rx_pop_o,
   output logic              rx_flush_o,
   output logic              tx_flush_o,
   output logic              rx_en_o,
   output logic              tx_en_o,
   output logic [1:0]        word_len_o,
   output logic [2:0]        parity_mode_o,
   output logic              stop_two_o,
   output logic              fifo_deep_o,
   output logic              tx_half_o,
   output logic              break_o,
   output logic [DATA_W-1:0] clk_sel_o
);

   localparam int ERR_CNT = 4;
   localparam logic [OFS_W-1:0] A_MODE = OFS_W'(OFS_MODE);
   localparam logic [OFS_W-1:0] A_STAT = OFS_W'(OFS_STAT);
   localparam logic [OFS_W-1:0] A_CMD  = OFS_W'(OFS_CMD);
   localparam logic [OFS_W-1:0] A_HOLD = OFS_W'(OFS_HOLD);

   initial begin
      assert (DATA_W == 8) else $error("uart_chan_regs: DATA_W must be 8");
      assert (OFS_W >= 2)  else $error("uart_chan_regs: OFS_W must cover four offsets");
   end

   cmd_t              cmd;
   logic [DATA_W-1:0] fifo_mr, fmt_mr, stop_mr, cur_mr, status;
   logic              mode_acc, mode_wr;

   assign mode_acc = (wr_en || rd_en) && addr == A_MODE;
   assign mode_wr  = wr_en && addr == A_MODE;

   uart_cmd_decode #(.DATA_W(DATA_W), .HAS_FIFO_MR(HAS_FIFO_MR)) u_dec (
      .cmd_wr   (wr_en && addr == A_CMD),
      .cmd_byte (wdata),
      .cmd      (cmd)
   );

   uart_mode_regs #(.DATA_W(DATA_W), .HAS_FIFO_MR(HAS_FIFO_MR)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_acc (mode_acc),
      .mode_wr  (mode_wr),
      .wdata    (wdata),
      .go_fmt   (cmd.ptr_fmt || cmd.rx_rst || cmd.tx_rst),
      .go_fifo  (cmd.ptr_fifo),
      .fifo_mr  (fifo_mr),
      .fmt_mr   (fmt_mr),
      .stop_mr  (stop_mr),
      .cur_mr   (cur_mr)
   );

   uart_status_reg #(.DATA_W(DATA_W), .ERR_CNT(ERR_CNT)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_rdy   (rx_rdy_i),
      .rx_full  (rx_full_i),
      .tx_rdy   (tx_rdy_i),
      .tx_empty (tx_empty_i),
      .err_in   ({brk_pulse_i, frm_pulse_i, par_pulse_i, ovr_pulse_i}),
      .err_clr  (cmd.err_clr),
      .chg_clr  (cmd.chg_clr),
      .rx_rst   (cmd.rx_rst),
      .status   (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_o <= 1'b0;
         tx_en_o <= 1'b0;
         break_o <= 1'b0;
      end else begin
         if (cmd.rx_off)                     rx_en_o <= 1'b0;
         else if (cmd.rx_on)                 rx_en_o <= 1'b1;
         else if (cmd.rx_rst)                rx_en_o <= 1'b0;
         if (cmd.tx_off)                     tx_en_o <= 1'b0;
         else if (cmd.tx_on)                 tx_en_o <= 1'b1;
         else if (cmd.tx_rst)                tx_en_o <= 1'b0;
         if (cmd.tx_rst || cmd.brk_off)      break_o <= 1'b0;
         else if (cmd.brk_on)                break_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      clk_sel_o <= '0;
      else if (wr_en && addr == A_STAT) clk_sel_o <= wdata;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            A_MODE:  rdata = cur_mr;
            A_STAT:  rdata = status;
            A_HOLD:  rdata = rx_data_i;
            default: rdata = '0;
         endcase
      end
   end

   assign tx_push_o     = wr_en && addr == A_HOLD;
   assign tx_data_o     = wdata;
   assign rx_pop_o      = rd_en && addr == A_HOLD;
   assign rx_flush_o    = cmd.rx_rst;
   assign tx_flush_o    = cmd.tx_rst;
   assign word_len_o    = fmt_mr[1:0];
   assign parity_mode_o = fmt_mr[4:2];
   assign stop_two_o    = stop_mr[3];
   assign fifo_deep_o   = fifo_mr[3];
   assign tx_half_o     = fifo_mr[4];

   AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && wdata[1]) |=> !rx_en_o); // R3
   AST_TX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && wdata[3]) |=> !tx_en_o); // R3
   AST_TXRST_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush_o |=> !break_o); // R13
   AST_BREAK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_CMD) |=> $stable(break_o)); // R11
   AST_RXRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flush_o && !wdata[0]) |=> !rx_en_o); // R12

endmodule

// File: tb/test_uart_chan_regs.sv
`timescale 1ns/1ps
module test_uart_chan_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0, rdata, rx_data_i = '0;
   logic       rx_rdy_i = 0, rx_full_i = 0, tx_rdy_i = 0, tx_empty_i = 0;
   logic       ovr_pulse_i = 0, par_pulse_i = 0, frm_pulse_i = 0, brk_pulse_i = 0;
   logic       tx_push_o, rx_pop_o, rx_flush_o, tx_flush_o, rx_en_o, tx_en_o;
   logic [7:0] tx_data_o, clk_sel_o;
   logic [1:0] word_len_o;
   logic [2:0] parity_mode_o;
   logic       stop_two_o, fifo_deep_o, tx_half_o, break_o;

   always #10 clk = ~clk;

   uart_chan_regs i_uart_chan_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rx_data_i(rx_data_i), .rx_rdy_i(rx_rdy_i),
      .rx_full_i(rx_full_i), .tx_rdy_i(tx_rdy_i), .tx_empty_i(tx_empty_i),
      .ovr_pulse_i(ovr_pulse_i), .par_pulse_i(par_pulse_i), .frm_pulse_i(frm_pulse_i),
      .brk_pulse_i(brk_pulse_i), .tx_push_o(tx_push_o), .tx_data_o(tx_data_o),
      .rx_pop_o(rx_pop_o), .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o),
      .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .word_len_o(word_len_o),
      .parity_mode_o(parity_mode_o), .stop_two_o(stop_two_o), .fifo_deep_o(fifo_deep_o),
      .tx_half_o(tx_half_o), .break_o(break_o), .clk_sel_o(clk_sel_o)
   );

   // reference model state
   int   m_ptr;
   int   m_mr[3];
   bit   m_rxen, m_txen, m_brk, m_mask;
   bit [3:0] m_err;
   int   m_csr;

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic int exp_rdata();
      if (!rd_en) return 0;
      case (addr)
         2'd0: return m_mr[m_ptr];
         2'd1: return {m_err, tx_empty_i, tx_rdy_i, rx_full_i & ~m_mask, rx_rdy_i & ~m_mask};
         2'd3: return rx_data_i;
         default: return 0;
      endcase
   endfunction

   task automatic check_comb();
      bit cmdw;
      cmdw = wr_en && addr == 2'd2;
      chk("R1", "rdata", rdata, exp_rdata());
      chk("R1", "tx_push", tx_push_o, wr_en && addr == 2'd3);
      chk("R1", "rx_pop", rx_pop_o, rd_en && addr == 2'd3);
      if (wr_en && addr == 2'd3) chk("R1", "tx_data", tx_data_o, wdata);
      chk("R12", "rx_flush", rx_flush_o, cmdw && wdata[7:4] == 4'h2);
      chk("R13", "tx_flush", tx_flush_o, cmdw && wdata[7:4] == 4'h3);
   endtask

   task automatic model_update();
      bit rdy_or_full;
      rdy_or_full = rx_rdy_i | rx_full_i;
      if ((wr_en || rd_en) && addr == 2'd0) begin
         if (wr_en) m_mr[m_ptr] = wdata;
         m_ptr = (m_ptr == 2) ? 2 : m_ptr + 1;
      end
      if (wr_en && addr == 2'd1) m_csr = wdata;
      if (wr_en && addr == 2'd2) begin
         case (wdata[7:4])
            4'h1: m_ptr = 1;
            4'h2: begin m_ptr = 1; m_rxen = 0; end
            4'h3: begin m_ptr = 1; m_txen = 0; m_brk = 0; end
            4'h4: m_err = 0;
            4'h5: m_err[3] = 0;
            4'h6: m_brk = 1;
            4'h7: m_brk = 0;
            4'hB: m_ptr = 0;
            default: ;
         endcase
         if (wdata[0]) m_rxen = 1;
         if (wdata[1]) m_rxen = 0;
         if (wdata[2]) m_txen = 1;
         if (wdata[3]) m_txen = 0;
      end
      m_err = m_err | {brk_pulse_i, frm_pulse_i, par_pulse_i, ovr_pulse_i};
      if (wr_en && addr == 2'd2 && wdata[7:4] == 4'h2) m_mask = 1;
      else if (!rdy_or_full) m_mask = 0;
   endtask

   task automatic check_regs();
      chk("R3", "rx_en", rx_en_o, m_rxen);
      chk("R3", "tx_en", tx_en_o, m_txen);
      chk("R6", "word_len", word_len_o, m_mr[1] & 3);
      chk("R6", "parity_mode", parity_mode_o, (m_mr[1] >> 2) & 7);
      chk("R7", "stop_two", stop_two_o, (m_mr[2] >> 3) & 1);
      chk("R8", "fifo_deep", fifo_deep_o, (m_mr[0] >> 3) & 1);
      chk("R8", "tx_half", tx_half_o, (m_mr[0] >> 4) & 1);
      chk("R11", "break", break_o, m_brk);
      chk("R1", "clk_sel", clk_sel_o, m_csr);
   endtask

   task automatic step(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
      wr_en = w; rd_en = r; addr = a; wdata = d;
      #1;
      check_comb();
      @(posedge clk);
      model_update();
      @(negedge clk);
      check_regs();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d); step(1, 0, a, d); endtask
   task automatic rd(input logic [1:0] a);                      step(0, 1, a, 8'h00); endtask
   task automatic idle();                                       step(0, 0, 2'd0, 8'h00); endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
   end

   initial begin
      m_ptr = 1; m_mr[0] = 0; m_mr[1] = 0; m_mr[2] = 0;
      m_rxen = 0; m_txen = 0; m_brk = 0; m_mask = 0; m_err = 0; m_csr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: reset state
      check_regs();
      chk("R2", "reset status", {i_uart_chan_regs.rdata}, 0);
      tx_rdy_i = 1; tx_empty_i = 1;
      rd(2'd1);                 // R2: held error bits zero, live bits pass (R9)
      rd(2'd0);                 // R2/R5: pointer at format register, read advances
      // R5: three writes after repointing; third stays on stop register
      wr(2'd2, 8'h10);          // R4
      wr(2'd0, 8'h07);          // R6: 8 bits, odd parity
      wr(2'd0, 8'h0F);          // R7: two stop bits
      wr(2'd0, 8'h07);          // R7/R5: overwrite stop register, one stop bit
      rd(2'd0);
      // R4/R8: FIFO-mode register via nibble B
      wr(2'd2, 8'hB0);
      wr(2'd0, 8'h18);          // R8
      wr(2'd0, 8'h10);          // R6: 5 bits, no parity
      rd(2'd0);                 // R5: read shows stop register
      wr(2'd2, 8'hB0);
      rd(2'd0);                 // R5: read of FIFO-mode register advances
      rd(2'd0);
      // R3: enable and disable bits
      wr(2'd2, 8'h05);
      wr(2'd2, 8'h03);          // R3 rx both: disable wins
      wr(2'd2, 8'h0C);          // R3 tx both: disable wins
      wr(2'd2, 8'h05);
      rd(2'd2);                 // R1: command offset reads 0
      // R11 / R13: break control
      wr(2'd2, 8'h60);
      idle();
      wr(2'd2, 8'h70);
      wr(2'd2, 8'h60);
      wr(2'd2, 8'h30);          // R13: tx reset drops break, tx_en, repoints
      rd(2'd0);
      // R12: receiver reset with engine flags high, combined with tx enable (R3)
      rx_rdy_i = 1; rx_full_i = 1;
      wr(2'd2, 8'h05);
      wr(2'd2, 8'h24);
      rd(2'd1);                 // R12 masked
      idle();
      rd(2'd1);
      rx_rdy_i = 0; rx_full_i = 0;
      idle();
      rx_rdy_i = 1;
      rd(2'd1);                 // R12 mask released
      rx_rdy_i = 0;
      // R9 / R10: held error bits
      ovr_pulse_i = 1; idle(); ovr_pulse_i = 0;
      rd(2'd1);
      par_pulse_i = 1; frm_pulse_i = 1; idle(); par_pulse_i = 0; frm_pulse_i = 0;
      brk_pulse_i = 1; idle(); brk_pulse_i = 0;
      rd(2'd1);
      wr(2'd2, 8'h50);          // R10: only bit 7 cleared
      rd(2'd1);
      wr(2'd2, 8'h40);          // R10: all cleared
      rd(2'd1);
      par_pulse_i = 1; wr(2'd2, 8'h40); par_pulse_i = 0;  // R10: pulse beats clear
      rd(2'd1);
      brk_pulse_i = 1; wr(2'd2, 8'h50); brk_pulse_i = 0;
      rd(2'd1);
      // R1: clock select and holding registers
      wr(2'd1, 8'h66);
      wr(2'd3, 8'hA5);
      rx_data_i = 8'h3C;
      rd(2'd3);
      idle();
      report();
   end

endmodule